// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block is a processor-bus peripheral offering 24 general-purpose lines. The lines form three 8-bit ports, A, B and C. They are split into two groups of twelve. The upper group holds port A and the upper half of port C. The lower group holds port B and the lower half of port C. Each group keeps its own operating-mode field and its own direction bits. The direction bits set which pins are driven and what a read of each port returns.

A host reaches the block over an 8-bit data bus. The bus uses a 2-bit address and three active-low strobes: chip select, read and write. All strobes are sampled on one system clock. Address 3 is the control register. A control write with bit 7 high loads the mode and direction word. A control write with bit 7 low sets or clears one chosen bit of port C. This avoids a read-modify-write of the whole port.

The pins appear as separate input, output and output-enable vectors, and the data bus as separate in, out and enable vectors. Pad drivers sit outside the block.

Top module: `pio_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises until the first write, every pin output enable is 0, every output latch is 0, and the control register reads 0x80: mode 0 and all ports input.
- R2: data_oe_o is 1 exactly while cs_ni and rd_ni are both low; otherwise it is 0.
- R3: Address 0 selects port A, 1 port B, 2 port C and 3 the control register. A write takes effect at the first clock edge at which the selected write strobe is sampled inactive. It uses the address and data sampled on the last cycle of the strobe.
- R4: A control write with data bit 7 = 1 loads the configuration. Bits 1:0 are the upper-group mode, bit 2 the lower-group mode, bit 3 port A output, bit 4 port C upper-nibble output, bit 5 port B output and bit 6 port C lower-nibble output (1 = output).
- R5: Each output-enable vector is all ones over the lines whose direction bit selects output and all zeros elsewhere.
- R6: A read of a port returns the output latch on output lines and the live pin value on input lines. Port C is resolved per nibble.
- R7: A control write with data bit 7 = 0 writes bit 0 into port C latch bit number data[3:1]. All other latch bits are unchanged and data bits 6:4 are ignored.
- R8: Port writes and single-bit writes update the latch even while the lines are inputs. The stored value is driven once the lines become outputs.
- R9: A control read returns bit 7 = 1 and the stored configuration in the R4 layout. An upper-group mode code of 3 is stored as 2, and the lower-group mode holds only 0 or 1.
- R10: Writing a port whose lines are inputs leaves its reads showing the pins.
- R11: A write strobe while cs_ni is high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data |
| data_oe_o | output | 1 | Bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C drive enable |

## Verification
The hardest state to observe is a port C latch bit that changed while its nibble was still an input. Reads then show only the pins, so a wrong single-bit update stays hidden. The stimulus applies several single-bit writes, including one with junk in bits 6:4, while the lower nibble is an input. It then turns every line to output and reads port C back, so each of those earlier updates becomes visible in one value.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NPORT  = 3;
  localparam int unsigned IDX_W  = $clog2(PORT_W);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd3;

  typedef struct packed {
    logic       c_lo_out;
    logic       b_out;
    logic       c_hi_out;
    logic       a_out;
    logic       b_mode;
    logic [1:0] a_mode;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RST = '0;
endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PORT_W-1:0] data_o
);
  logic wr_act, wr_q;

  assign wr_act   = ~cs_ni & ~wr_ni;
  assign commit_o = wr_q & ~wr_act;  // trailing edge of strobe

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/pio_cfg.sv
module pio_cfg
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output pio_cfg_t          cfg_o,
  output logic              bsr_o,
  output logic [IDX_W-1:0]  bsr_idx_o,
  output logic              bsr_val_o
);
  logic ctrl_wr;

  assign ctrl_wr   = commit_i && (addr_i == CTRL_ADDR);
  assign bsr_o     = ctrl_wr & ~data_i[PORT_W-1];
  assign bsr_idx_o = data_i[IDX_W:1];
  assign bsr_val_o = data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RST;
    end else if (ctrl_wr && data_i[PORT_W-1]) begin
      cfg_o          <= pio_cfg_t'(data_i[6:0]);
      cfg_o.a_mode   <= (data_i[1:0] == 2'd3) ? 2'd2 : data_i[1:0];
    end
  end
endmodule

// File: rtl/pio_latch.sv
module pio_latch
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic              bsr_i,
  input  logic [IDX_W-1:0]  bsr_idx_i,
  input  logic              bsr_val_i,
  output logic [PORT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= wr_data_i;
    else if (bsr_i) q_o[bsr_idx_i] <= bsr_val_i;
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  localparam int unsigned HALF = PORT_W / 2;

  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [PORT_W-1:0] wr_data;
  pio_cfg_t          cfg;
  logic              bsr;
  logic [IDX_W-1:0]  bsr_idx;
  logic              bsr_val;

  logic [PORT_W-1:0] pin_in [NPORT];
  logic [PORT_W-1:0] lat_q  [NPORT];
  logic [PORT_W-1:0] oe_m   [NPORT];
  logic [PORT_W-1:0] rd_val [NPORT];

  pio_bus_if i_bus (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .addr_i, .data_i,
    .commit_o(wr_commit), .addr_o(wr_addr), .data_o(wr_data)
  );

  pio_cfg i_cfg (
    .clk_i, .rst_ni,
    .commit_i(wr_commit), .addr_i(wr_addr), .data_i(wr_data),
    .cfg_o(cfg), .bsr_o(bsr), .bsr_idx_o(bsr_idx), .bsr_val_o(bsr_val)
  );

  assign pin_in[0] = pa_i;
  assign pin_in[1] = pb_i;
  assign pin_in[2] = pc_i;
  assign oe_m[0]   = {PORT_W{cfg.a_out}};
  assign oe_m[1]   = {PORT_W{cfg.b_out}};
  assign oe_m[2]   = {{HALF{cfg.c_hi_out}}, {HALF{cfg.c_lo_out}}};

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(g);
    localparam bit HAS_BSR = (g == NPORT - 1);
    pio_latch i_lat (
      .clk_i, .rst_ni,
      .wr_i(wr_commit && (wr_addr == PADDR)),
      .wr_data_i(wr_data),
      .bsr_i(bsr & HAS_BSR),
      .bsr_idx_i(bsr_idx),
      .bsr_val_i(bsr_val),
      .q_o(lat_q[g])
    );
    assign rd_val[g] = (lat_q[g] & oe_m[g]) | (pin_in[g] & ~oe_m[g]);
  end

  assign pa_o    = lat_q[0];
  assign pb_o    = lat_q[1];
  assign pc_o    = lat_q[2];
  assign pa_oe_o = oe_m[0];
  assign pb_oe_o = oe_m[1];
  assign pc_oe_o = oe_m[2];

  assign data_oe_o = ~cs_ni & ~rd_ni;
  always_comb begin
    if (addr_i == CTRL_ADDR) data_o = {1'b1, cfg};
    else                     data_o = rd_val[addr_i];
  end
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
  import pio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              data_oe_o,
  input logic [PORT_W-1:0] pa_o,
  input logic [PORT_W-1:0] pa_oe_o,
  input logic [PORT_W-1:0] pc_o,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] wr_addr
);
  // R2
  bus_drive_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!cs_ni && !rd_ni));

  // R2
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);

  // R4
  dir_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pa_oe_o) |-> $past(wr_commit && wr_addr == CTRL_ADDR));

  // R7
  bsr_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_commit && wr_addr == CTRL_ADDR) |-> $countones(pc_o ^ $past(pc_o)) <= 1);

  // R11
  pa_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_commit && wr_addr == 2'd0) |-> $stable(pa_o));
endmodule

bind pio_ctrl pio_ctrl_chk i_chk (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .data_oe_o,
  .pa_o, .pa_oe_o, .pc_o, .wr_commit, .wr_addr
);

// File: tb/test_pio_ctrl.sv
module test_pio_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0, pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] data_o, pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic       data_oe_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pio_ctrl i_pio_ctrl (.*);

  typedef struct packed {
    logic       rd;
    logic [1:0] addr;
    logic [7:0] data, pa, pb, pc, exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd3, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h80}, // R1 ctrl after reset
    '{1'b1, 2'd0, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h5A}, // R6 input A
    '{1'b0, 2'd0, 8'h3C, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R8 write A while input
    '{1'b1, 2'd0, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h5A}, // R10 still pins
    '{1'b0, 2'd3, 8'h99, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R4 A out, Chi out, A mode 1
    '{1'b1, 2'd3, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h99}, // R9 readback
    '{1'b1, 2'd0, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h3C}, // R8 R6 latch shows
    '{1'b0, 2'd2, 8'hA5, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R3 write C
    '{1'b1, 2'd2, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'hA6}, // R6 per nibble
    '{1'b0, 2'd3, 8'h0A, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R7 clear bit5
    '{1'b1, 2'd2, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h86}, // R7
    '{1'b0, 2'd3, 8'h0D, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R7 set bit6
    '{1'b1, 2'd2, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'hC6}, // R7
    '{1'b0, 2'd3, 8'h70, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R7 clear bit0, junk 6:4
    '{1'b1, 2'd2, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'hC6}, // R6 lower still pins
    '{1'b0, 2'd3, 8'hFF, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R4 all out, mode codes 3/1
    '{1'b1, 2'd3, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'hFE}, // R9 clamp A mode
    '{1'b1, 2'd2, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'hC4}, // R7 R8 hidden updates
    '{1'b1, 2'd1, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R6 B latch
    '{1'b0, 2'd1, 8'h77, 8'h5A, 8'hC3, 8'h96, 8'h00}, // R3 write B
    '{1'b1, 2'd1, 8'h00, 8'h5A, 8'hC3, 8'h96, 8'h77}  // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic cs);
    @(negedge clk_i);
    cs_ni = cs; wr_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk_i); @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0; addr_i = a;
    #5 d = data_o;
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    chk("R1 pa_oe", pa_oe_o, 8'h00);
    chk("R1 pc_o", pc_o, 8'h00);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      pa_i = VEC[i].pa; pb_i = VEC[i].pb; pc_i = VEC[i].pc;
      if (VEC[i].rd) begin
        bus_rd(VEC[i].addr, r);
        chk($sformatf("vec%0d", i), r, VEC[i].exp);
      end else begin
        bus_wr(VEC[i].addr, VEC[i].data, 1'b0);
      end
    end
    // R5 all outputs enabled
    chk("R5 pa_oe", pa_oe_o, 8'hFF);
    chk("R5 pc_oe", pc_oe_o, 8'hFF);
    chk("R5 pa_o", pa_o, 8'h3C);
    // R2 bus enable
    @(negedge clk_i); cs_ni = 1'b1; rd_ni = 1'b0; #5;
    chk("R2 unselected", {7'd0, data_oe_o}, 8'h00);
    cs_ni = 1'b0; #1;
    chk("R2 selected", {7'd0, data_oe_o}, 8'h01);
    cs_ni = 1'b1; rd_ni = 1'b1; #1;
    chk("R2 released", {7'd0, data_oe_o}, 8'h00);
    // R11 write without select
    bus_wr(2'd0, 8'h11, 1'b1);
    bus_rd(2'd0, r);
    chk("R11 ignored", r, 8'h3C);
    // R3 commit timing
    @(negedge clk_i);
    cs_ni = 1'b0; wr_ni = 1'b0; addr_i = 2'd0; data_i = 8'hE1;
    @(negedge clk_i); @(negedge clk_i);
    data_i = 8'h00; cs_ni = 1'b1; wr_ni = 1'b1;
    chk("R3 before commit", pa_o, 8'h3C);
    @(negedge clk_i);
    chk("R3 after commit", pa_o, 8'hE1);
    // R9 group A mode code 3 stored as 2
    bus_wr(2'd3, 8'h83, 1'b0);
    bus_rd(2'd3, r);
    chk("R9 clamp", r, 8'h82);
    // R1 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 pa_o", pa_o, 8'h00);
    chk("R1 pb_oe", pb_oe_o, 8'h00);
    rst_ni = 1'b1;
    bus_rd(2'd3, r);
    chk("R1 ctrl", r, 8'h80);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule